// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block is the command front end of a byte-wide parallel flash device with an internal array of 512K x 8. The host talks to it through chip-enable, write-enable and output-enable strobes, an address bus, and a data bus. The data bus is split into an input, an output and an output enable. Bus writes are decoded into commands through a keyed unlock sequence. A recognised command starts an embedded operation: byte program, sector erase or chip erase. Each operation runs on its own, with its pulse lengths counted in clock cycles.

While an operation runs, a read from the host returns a status byte instead of array data. One bit of that byte flips on every read cycle. Another bit gives a data-polling answer. Once the operation is over, reads return array contents again. The array itself sits outside the block, behind a small port that carries an address, a read byte, a program strobe with write data, and a sector erase strobe.

An erase first programs every byte of the target region to 00h. It then applies timed erase pulses and reads the region back, and it repeats the pulse until every byte reads FFh. A running sector erase can be suspended and later resumed. A running program or chip erase cannot be disturbed by the bus at all.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is in read mode. `dq_oe` is high only while a read cycle is open (`ce_n`=0, `oe_n`=0, `we_n`=1), and an idle read returns the array byte at `addr`.
- R2: A write cycle is the span where `ce_n` and `we_n` are both low. The address is sampled when that span opens and the data when it closes, so later address changes and earlier data values have no effect.
- R3: Byte program: write AAh at low address 555h, then 55h at low address 2AAh, then A0h at any address, then the data at the target address. The target byte then reads back as that data. Only address bits [10:0] take part in key matching.
- R4: A write that does not match the next expected step of any sequence returns the decoder to read mode and changes no array byte. A correct sequence given afterwards works.
- R5: While a program runs, every bus write is ignored, including complete command sequences and B0h.
- R6: While busy, reads return a status byte: bit 6 takes the opposite value on each successive read cycle, and bits 5..0 are 0.
- R7: While busy, status bit 7 is the inverse of bit 7 of the byte being programmed during a program, and 0 during any erase. After completion, reads return true array data.
- R8: Sector erase: AAh@555h, 55h@2AAh, 80h, AAh@555h, 55h@2AAh, then 30h written to any address inside the sector. The sector is named by address bits [top:top-2]. Every byte of that sector ends at FFh and the other sectors keep their contents.
- R9: Chip erase: the same five-write prefix as R8, then 10h at low address 555h. Every byte of the array ends at FFh.
- R10: During a sector erase, a write of B0h suspends it. While suspended, the erase makes no progress, reads return array data, and array bytes stay unchanged. The only write accepted is 30h, which resumes the erase to completion.
- R11: While a chip erase runs, every bus write is ignored, B0h included, and status keeps toggling.
- R12: After any operation completes, the full command set is accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address from the host |
| dq_i | input | 8 | Data bus, host to device |
| dq_o | output | 8 | Data bus, device to host (array byte or status) |
| dq_oe | output | 1 | High when the device drives the data bus |
| arr_addr | output | ADDR_W | Array address: the engine's address while busy, otherwise `addr` |
| arr_rdata | input | 8 | Array byte at `arr_addr`, combinational |
| arr_prog | output | 1 | One-cycle program strobe writing `arr_wdata` at `arr_addr` |
| arr_wdata | output | 8 | Byte to program |
| arr_erase | output | 1 | One-cycle strobe that erases the sector named by the top three bits of `arr_addr` |

## Verification
The bench skews its writes: it moves the address after a write cycle has opened and presents the data only just before the cycle closes. A design that samples on the wrong edge writes a garbage byte at a garbage address. Broken unlock sequences, and complete command sequences issued while a program or chip erase runs, must leave untouched bytes at their preloaded values. A decoder that is not locked out corrupts those bytes, or starts a second operation. In a sector erase suspended part-way through preprogramming, a byte not yet reached must keep its value across a wait. A design that keeps stepping, or that accepts a program while suspended, shows a changed byte. Status reads check the polling bit against the inverted data bit, and check that bit 6 flips between back-to-back reads.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    DEC_READ, DEC_KEY1, DEC_KEY2, DEC_PGM, DEC_EKEY0, DEC_EKEY1, DEC_ESEL
  } dec_state_t;

  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_CHIP, OP_SECT} op_t;

  typedef enum logic [2:0] {
    ENG_IDLE, ENG_PPULSE, ENG_PWRITE, ENG_PVERIFY,
    ENG_PREPROG, ENG_EPULSE, ENG_EAPPLY, ENG_EVERIFY
  } eng_state_t;

  localparam logic [10:0] KEY_ADDR_A = 11'h555;
  localparam logic [10:0] KEY_ADDR_B = 11'h2AA;
  localparam logic [7:0]  KEY_DATA_A = 8'hAA;
  localparam logic [7:0]  KEY_DATA_B = 8'h55;
  localparam logic [7:0]  CMD_PROGRAM = 8'hA0;
  localparam logic [7:0]  CMD_ERASE   = 8'h80;
  localparam logic [7:0]  CMD_CHIP    = 8'h10;
  localparam logic [7:0]  CMD_SECTOR  = 8'h30;
  localparam logic [7:0]  CMD_SUSPEND = 8'hB0;
  localparam logic [7:0]  CMD_RESUME  = 8'h30;

  function automatic logic is_key_a(input logic [10:0] a, input logic [7:0] d);
    return (a == KEY_ADDR_A) && (d == KEY_DATA_A);
  endfunction

  function automatic logic is_key_b(input logic [10:0] a, input logic [7:0] d);
    return (a == KEY_ADDR_B) && (d == KEY_DATA_B);
  endfunction

  // bit 7: polling answer, bit 6: toggle, rest zero
  function automatic logic [7:0] status_byte(input op_t op, input logic [7:0] tgt,
                                             input logic tog);
    logic poll;
    poll = (op == OP_PROG) ? ~tgt[7] : 1'b0;
    return {poll, tog, 6'b0};
  endfunction

endpackage

// File: rtl/flash_bus_cap.sv
module flash_bus_cap #(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_i,
  output logic              wr_evt,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              rd_act,
  output logic              rd_end
);
  logic wr_act, wr_q, rd_q;
  logic wr_open, wr_close;

  assign wr_act   = ~ce_n & ~we_n;
  assign rd_act   = ~ce_n & ~oe_n & we_n;
  assign wr_open  = wr_act & ~wr_q;   // later of the two falling edges
  assign wr_close = ~wr_act & wr_q;   // first of the two rising edges
  assign rd_end   = rd_q & ~rd_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      wr_evt  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_q   <= wr_act;
      rd_q   <= rd_act;
      wr_evt <= wr_close;
      if (wr_open)  wr_addr <= addr;
      if (wr_close) wr_data <= dq_i;
    end
  end
endmodule

// File: rtl/flash_cmd_dec.sv
module flash_cmd_dec
  import flash_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_evt,
  input  logic [10:0] wr_low,
  input  logic [7:0]  wr_data,
  input  logic        eng_idle,
  input  logic        sect_run,
  input  logic        eng_susp,
  output logic        go_prog,
  output logic        go_chip,
  output logic        go_sect,
  output logic        go_susp,
  output logic        go_res
);
  dec_state_t st, st_nxt;

  always_comb begin
    st_nxt  = st;
    go_prog = 1'b0;
    go_chip = 1'b0;
    go_sect = 1'b0;
    go_susp = 1'b0;
    go_res  = 1'b0;
    if (wr_evt) begin
      st_nxt = DEC_READ;
      if (sect_run) begin
        go_susp = (wr_data == CMD_SUSPEND);
      end else if (eng_susp) begin
        go_res = (wr_data == CMD_RESUME);
      end else if (eng_idle) begin
        case (st)
          DEC_READ:  if (is_key_a(wr_low, wr_data)) st_nxt = DEC_KEY1;
          DEC_KEY1:  if (is_key_b(wr_low, wr_data)) st_nxt = DEC_KEY2;
          DEC_KEY2: begin
            if (wr_data == CMD_PROGRAM)    st_nxt = DEC_PGM;
            else if (wr_data == CMD_ERASE) st_nxt = DEC_EKEY0;
          end
          DEC_PGM:   go_prog = 1'b1;
          DEC_EKEY0: if (is_key_a(wr_low, wr_data)) st_nxt = DEC_EKEY1;
          DEC_EKEY1: if (is_key_b(wr_low, wr_data)) st_nxt = DEC_ESEL;
          DEC_ESEL: begin
            go_chip = (wr_data == CMD_CHIP) && (wr_low == KEY_ADDR_A);
            go_sect = (wr_data == CMD_SECTOR);
          end
          default:   st_nxt = DEC_READ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= DEC_READ;
    else        st <= st_nxt;
  end
endmodule

// File: rtl/flash_embed_eng.sv
module flash_embed_eng
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_prog,
  input  logic              go_chip,
  input  logic              go_sect,
  input  logic              go_susp,
  input  logic              go_res,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic [7:0]        arr_rdata,
  output logic [ADDR_W-1:0] eng_addr,
  output logic              eng_prog,
  output logic [7:0]        eng_wdata,
  output logic              eng_erase,
  output logic              eng_run,
  output logic              eng_susp,
  output op_t               eng_op,
  output logic [7:0]        tgt_data
);
  localparam int SEC_W = ADDR_W - 3;
  localparam int CMAX  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW    = $clog2(CMAX + 1);

  function automatic logic [2:0] sector_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: 3];
  endfunction

  eng_state_t        st;
  logic [2:0]        sec, sec_last;
  logic [SEC_W-1:0]  off;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] tgt_addr;
  logic              off_end;

  assign off_end   = &off;
  assign eng_run   = (st != ENG_IDLE);
  assign eng_prog  = ~eng_susp & ((st == ENG_PWRITE) || (st == ENG_PREPROG));
  assign eng_wdata = (st == ENG_PWRITE) ? tgt_data : 8'h00;
  assign eng_erase = ~eng_susp & (st == ENG_EAPPLY);
  assign eng_addr  = (eng_op == OP_PROG) ? tgt_addr : {sec, off};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ENG_IDLE;
      eng_op   <= OP_NONE;
      eng_susp <= 1'b0;
      sec      <= '0;
      sec_last <= '0;
      off      <= '0;
      cnt      <= '0;
      tgt_addr <= '0;
      tgt_data <= '0;
    end else begin
      if (go_susp && eng_op == OP_SECT && eng_run) eng_susp <= 1'b1;
      if (go_res) eng_susp <= 1'b0;
      if (!eng_susp) begin
        case (st)
          ENG_IDLE: begin
            if (go_prog) begin
              eng_op   <= OP_PROG;
              tgt_addr <= cmd_addr;
              tgt_data <= cmd_data;
              cnt      <= '0;
              st       <= ENG_PPULSE;
            end else if (go_chip) begin
              eng_op   <= OP_CHIP;
              sec      <= 3'd0;
              sec_last <= 3'd7;
              off      <= '0;
              st       <= ENG_PREPROG;
            end else if (go_sect) begin
              eng_op   <= OP_SECT;
              sec      <= sector_of(cmd_addr);
              sec_last <= sector_of(cmd_addr);
              off      <= '0;
              st       <= ENG_PREPROG;
            end
          end
          ENG_PPULSE: begin
            if (cnt == CW'(PROG_CYC - 1)) st <= ENG_PWRITE;
            else                          cnt <= cnt + 1'b1;
          end
          ENG_PWRITE: st <= ENG_PVERIFY;
          ENG_PVERIFY: begin
            if (arr_rdata == tgt_data) st <= ENG_IDLE;
            else begin
              cnt <= '0;
              st  <= ENG_PPULSE;
            end
          end
          ENG_PREPROG: begin
            if (off_end) begin
              off <= '0;
              cnt <= '0;
              st  <= ENG_EPULSE;
            end else begin
              off <= off + 1'b1;
            end
          end
          ENG_EPULSE: begin
            if (cnt == CW'(ERASE_CYC - 1)) st <= ENG_EAPPLY;
            else                           cnt <= cnt + 1'b1;
          end
          ENG_EAPPLY: begin
            off <= '0;
            st  <= ENG_EVERIFY;
          end
          ENG_EVERIFY: begin
            if (arr_rdata != 8'hFF) begin
              cnt <= '0;
              st  <= ENG_EPULSE;
            end else if (off_end) begin
              if (sec == sec_last) st <= ENG_IDLE;
              else begin
                sec <= sec + 1'b1;
                off <= '0;
                st  <= ENG_PREPROG;
              end
            end else begin
              off <= off + 1'b1;
            end
          end
          default: st <= ENG_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_i,
  output logic [7:0]        dq_o,
  output logic              dq_oe,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic [7:0]        arr_rdata,
  output logic              arr_prog,
  output logic [7:0]        arr_wdata,
  output logic              arr_erase
);
  logic              wr_evt, rd_act, rd_end;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic              go_prog, go_chip, go_sect, go_susp, go_res;
  logic [ADDR_W-1:0] eng_addr;
  logic              eng_run, eng_susp, busy, sect_run, tog;
  op_t               eng_op;
  logic [7:0]        tgt_data;

  flash_bus_cap #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_i(dq_i), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_act(rd_act), .rd_end(rd_end)
  );

  flash_cmd_dec u_dec (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_low(wr_addr[10:0]),
    .wr_data(wr_data), .eng_idle(~eng_run), .sect_run(sect_run),
    .eng_susp(eng_susp), .go_prog(go_prog), .go_chip(go_chip),
    .go_sect(go_sect), .go_susp(go_susp), .go_res(go_res)
  );

  flash_embed_eng #(.ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .go_prog(go_prog), .go_chip(go_chip),
    .go_sect(go_sect), .go_susp(go_susp), .go_res(go_res),
    .cmd_addr(wr_addr), .cmd_data(wr_data), .arr_rdata(arr_rdata),
    .eng_addr(eng_addr), .eng_prog(arr_prog), .eng_wdata(arr_wdata),
    .eng_erase(arr_erase), .eng_run(eng_run), .eng_susp(eng_susp),
    .eng_op(eng_op), .tgt_data(tgt_data)
  );

  assign busy     = eng_run & ~eng_susp;
  assign sect_run = busy & (eng_op == OP_SECT);
  assign arr_addr = busy ? eng_addr : addr;
  assign dq_oe    = rd_act;
  assign dq_o     = busy ? status_byte(eng_op, tgt_data, tog) : arr_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n)              tog <= 1'b0;
    else if (rd_end && busy) tog <= ~tog;
  end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk
  import flash_seq_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic wr_evt,
  input logic busy,
  input logic eng_run,
  input logic eng_susp,
  input op_t  eng_op,
  input logic go_prog,
  input logic go_chip,
  input logic go_sect,
  input logic go_susp,
  input logic go_res,
  input logic arr_prog,
  input logic arr_erase
);
  // R2
  evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !wr_evt);
  // R3
  one_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_prog, go_chip, go_sect, go_susp, go_res}));
  // R5
  start_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_run |-> !(go_prog || go_chip || go_sect));
  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_prog && arr_erase));
  // R10
  susp_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_susp |-> (busy && eng_op == OP_SECT));
  // R10
  resume_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_res |-> eng_susp);
  // R11
  chip_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_run && eng_op == OP_CHIP) |=> !eng_susp);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .busy(busy),
  .eng_run(eng_run), .eng_susp(eng_susp), .eng_op(eng_op),
  .go_prog(go_prog), .go_chip(go_chip), .go_sect(go_sect),
  .go_susp(go_susp), .go_res(go_res),
  .arr_prog(arr_prog), .arr_erase(arr_erase)
);

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 11;
  localparam int SW   = AW - 3;
  localparam int SECN = 1 << SW;
  localparam int NV   = 6;
  localparam logic [18:0] PVEC [NV] = '{
    {11'h010, 8'h3C}, {11'h2AA, 8'hC5}, {11'h555, 8'hFF},
    {11'h7FF, 8'h80}, {11'h400, 8'h00}, {11'h123, 8'hA7}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] dq_i = '0;
  logic [7:0] dq_o;
  logic dq_oe;
  logic [AW-1:0] arr_addr;
  logic [7:0] arr_rdata, arr_wdata;
  logic arr_prog, arr_erase;
  logic [7:0] mem [1 << AW];
  int total = 0, bad = 0, cyc = 0;
  logic oe_seen;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flash_cmd_seq #(.ADDR_W(AW), .PROG_CYC(60), .ERASE_CYC(20)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
    .arr_addr(arr_addr), .arr_rdata(arr_rdata), .arr_prog(arr_prog),
    .arr_wdata(arr_wdata), .arr_erase(arr_erase)
  );

  // array model: preload during reset, plain write, sector erase to FF
  assign arr_rdata = mem[arr_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (1 << AW); i++) mem[i] <= 8'(i) ^ 8'h5A;
    end else begin
      if (arr_prog) mem[arr_addr] <= arr_wdata;
      if (arr_erase)
        for (int i = 0; i < SECN; i++) mem[{arr_addr[AW-1 -: 3], SW'(i)}] <= 8'hFF;
    end
  end

  function automatic logic [7:0] orig(input logic [AW-1:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
    addr = a; dq_i = d; ce_n = 1'b0; we_n = 1'b0;
    tick(2);
    we_n = 1'b1;
    tick(1);
    ce_n = 1'b1;
    tick(1);
  endtask

  // address moves after the cycle opens, data appears just before it closes
  task automatic bus_wr_skew(input logic [AW-1:0] a, input logic [7:0] d);
    addr = a; dq_i = ~d; ce_n = 1'b0; we_n = 1'b0;
    tick(1);
    addr = ~a;
    tick(1);
    dq_i = d;
    tick(1);
    we_n = 1'b1;
    tick(1);
    ce_n = 1'b1; dq_i = ~d;
    tick(1);
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [7:0] v);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    tick(1);
    v = dq_o;
    oe_seen = dq_oe;
    oe_n = 1'b1; ce_n = 1'b1;
    tick(1);
  endtask

  task automatic wait_done(input logic [AW-1:0] a);
    logic [7:0] v1, v2;
    bit done = 0;
    for (int k = 0; k < 3000 && !done; k++) begin
      bus_rd(a, v1);
      bus_rd(a, v2);
      if (v1 == v2) done = 1;
    end
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    bus_wr(11'h555, 8'hAA);
    bus_wr(11'h2AA, 8'h55);
    bus_wr(11'h000, 8'hA0);
    bus_wr(a, d);
  endtask

  task automatic erase_prefix();
    bus_wr(11'h555, 8'hAA);
    bus_wr(11'h2AA, 8'h55);
    bus_wr(11'h555, 8'h80);
    bus_wr(11'h555, 8'hAA);
    bus_wr(11'h2AA, 8'h55);
  endtask

  initial begin
    logic [7:0] s1, s2, v;
    tick(5);
    rst_n = 1'b1;
    tick(2);

    // R1: reset state and idle read
    check("R1 oe idle", {7'b0, dq_oe}, 8'h00);
    bus_rd(11'h00A, v);
    check("R1 read data", v, orig(11'h00A));
    check("R1 oe in read", {7'b0, oe_seen}, 8'h01);

    // R3 R6 R7: table of program vectors
    for (int i = 0; i < NV; i++) begin
      logic [AW-1:0] a;
      logic [7:0] d;
      a = PVEC[i][18:8];
      d = PVEC[i][7:0];
      prog(a, d);
      bus_rd(a, s1);
      check("R7 poll prog", {7'b0, s1[7]}, {7'b0, ~d[7]});
      check("R6 low bits", {2'b0, s1[5:0]}, 8'h00);
      bus_rd(a, s2);
      check("R6 toggle", {7'b0, s2[6]}, {7'b0, ~s1[6]});
      wait_done(a);
      bus_rd(a, v);
      check("R3 readback", v, d);
    end

    // R2: skewed write strobes
    bus_wr_skew(11'h555, 8'hAA);
    bus_wr_skew(11'h2AA, 8'h55);
    bus_wr_skew(11'h000, 8'hA0);
    bus_wr_skew(11'h0F0, 8'h42);
    wait_done(11'h0F0);
    bus_rd(11'h0F0, v);
    check("R2 capture edges", v, 8'h42);
    bus_rd(11'h70F, v);
    check("R2 no stray write", v, orig(11'h70F));

    // R4: broken unlock, then a correct sequence
    bus_wr(11'h555, 8'hAA);
    bus_wr(11'h123, 8'h55);
    bus_wr(11'h000, 8'hA0);
    bus_wr(11'h060, 8'h77);
    tick(4);
    bus_rd(11'h060, v);
    check("R4 broken seq", v, orig(11'h060));
    prog(11'h061, 8'h12);
    wait_done(11'h061);
    bus_rd(11'h061, v);
    check("R4 recovers", v, 8'h12);

    // R5: writes during program are ignored
    prog(11'h070, 8'h5C);
    prog(11'h080, 8'h99);
    bus_wr(11'h000, 8'hB0);
    wait_done(11'h070);
    bus_rd(11'h070, v);
    check("R5 own byte", v, 8'h5C);
    bus_rd(11'h080, v);
    check("R5 ignored prog", v, orig(11'h080));

    // R8: sector erase of sector 3
    erase_prefix();
    bus_wr(11'h345, 8'h30);
    bus_rd(11'h345, s1);
    check("R7 poll erase", {7'b0, s1[7]}, 8'h00);
    wait_done(11'h300);
    bus_rd(11'h300, v);
    check("R8 sector first", v, 8'hFF);
    bus_rd(11'h3A7, v);
    check("R8 sector mid", v, 8'hFF);
    bus_rd(11'h3FF, v);
    check("R8 sector last", v, 8'hFF);
    bus_rd(11'h2FF, v);
    check("R8 below kept", v, orig(11'h2FF));
    bus_rd(11'h401, v);
    check("R8 above kept", v, orig(11'h401));

    // R10: suspend and resume a sector erase of sector 5
    erase_prefix();
    bus_wr(11'h512, 8'h30);
    tick(100);
    bus_wr(11'h000, 8'hB0);
    bus_rd(11'h050, s1);
    bus_rd(11'h050, s2);
    check("R10 read array 1", s1, orig(11'h050));
    check("R10 read array 2", s2, orig(11'h050));
    bus_rd(11'h5FF, v);
    check("R10 frozen a", v, orig(11'h5FF));
    tick(50);
    bus_rd(11'h5FF, v);
    check("R10 frozen b", v, orig(11'h5FF));
    prog(11'h051, 8'h11);
    tick(80);
    bus_rd(11'h051, v);
    check("R10 prog ignored", v, orig(11'h051));
    bus_wr(11'h000, 8'h30);
    wait_done(11'h5FF);
    bus_rd(11'h5FF, v);
    check("R10 resumed last", v, 8'hFF);
    bus_rd(11'h500, v);
    check("R10 resumed first", v, 8'hFF);

    // R9 R11: chip erase ignores suspend
    erase_prefix();
    bus_wr(11'h555, 8'h10);
    bus_wr(11'h000, 8'hB0);
    bus_rd(11'h000, s1);
    bus_rd(11'h000, s2);
    check("R11 still toggling", {7'b0, s2[6]}, {7'b0, ~s1[6]});
    check("R11 poll zero", {7'b0, s1[7]}, 8'h00);
    wait_done(11'h000);
    bus_rd(11'h000, v);
    check("R9 chip low", v, 8'hFF);
    bus_rd(11'h3C0, v);
    check("R9 chip mid", v, 8'hFF);
    bus_rd(11'h7FF, v);
    check("R9 chip top", v, 8'hFF);

    // R12: full command set after completion
    prog(11'h234, 8'h5E);
    wait_done(11'h234);
    bus_rd(11'h234, v);
    check("R12 program after erase", v, 8'h5E);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule